// File: doc/BRIEF.md
# Byte-Masked Two-Port Register File

This block holds the general-purpose registers of a small processor core. It has two ports. The primary port reads and writes. On every cycle it takes an address, a data word and a mask with one write-enable bit per byte lane, and it returns a read word whether or not a lane is being written. The secondary port only reads. It takes an address and returns a word.

Every storage update and every read capture happens on the rising clock edge, and both read outputs are registered. A word written in a cycle is not forwarded to a read issued in that same cycle. Either port sees the new bytes from the next read onward. Any forwarding needed by the datapath is the job of the logic around this block. The register count, word width and lane width are parameters. The storage is built as one bank per byte lane.

Top module: `bytemask_regfile`

## Requirements
- R1: An active-low asynchronous reset clears every register and both read outputs to zero. The outputs read zero while reset is low, without waiting for a clock edge.
- R2: Read data is registered. An address presented on either port before rising edge N shows the addressed word on that port's read output after edge N, and the output holds that value until the next rising edge.
- R3: On a primary-port write, lane i (bits 8i+7 down to 8i) of the addressed register takes the matching write-data bits only when mask bit i is 1. Lanes whose mask bit is 0 keep their old contents.
- R4: The primary port reads on every cycle. In a cycle where it writes the register it addresses, its read output after that edge is the contents from before the write.
- R5: When the secondary port reads the register that the primary port writes in the same cycle, it returns the contents from before the write. The new bytes are visible to either port from the next read onward.
- R6: With an all-zero mask the primary port is a pure read port, and no register changes whatever the write data holds.
- R7: The two ports read independent addresses in the same cycle. When both address the same register, both return the same word.
- R8: Changes on the address, data or mask inputs between rising edges do not change the read outputs or the storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all captures and updates on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pa_addr | input | 5 | Primary port register index |
| pa_wdata | input | 32 | Primary port write word |
| pa_lane_we | input | 4 | Primary port per-byte write mask, bit i enables byte lane i |
| pa_rdata | output | 32 | Primary port registered read word |
| pb_addr | input | 5 | Secondary port register index |
| pb_rdata | output | 32 | Secondary port registered read word |

## Verification
Assertions watch four things on every cycle. They check that a lane write lands in the register it addressed. They check that a lane left unmasked keeps its contents. They check that both ports agree when they read the same register, including the case where the primary port writes that register in the same cycle. They also check that the outputs read zero while reset is held. Other behaviours can only be shown by the bench's scenarios, because they need the full history of the contents: the exact old-versus-new value in a read-during-write cycle, the read latency, mask patterns walked one after another on a single register, inputs moved between edges, and a reset in the middle of a run.

// File: rtl/rf_pkg.sv
package rf_pkg;
   function automatic int unsigned lanes_of(input int unsigned word_w,
                                             input int unsigned lane_w);
      return word_w / lane_w;
   endfunction

   function automatic int unsigned idx_bits(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction
endpackage

// File: rtl/rf_lane_bank.sv
module rf_lane_bank #(
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned IDX_W = rf_pkg::idx_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [LANE_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr_a,
   input  logic [IDX_W-1:0]  raddr_b,
   output logic [LANE_W-1:0] rlane_a,
   output logic [LANE_W-1:0] rlane_b
);
   logic [LANE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rlane_a = mem[raddr_a];
   assign rlane_b = mem[raddr_b];

   // R3
   lane_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(waddr)] == $past(wdata));

   // R6
   lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> mem[$past(raddr_a)] == $past(mem[raddr_a]));
endmodule

// File: rtl/rf_rd_stage.sv
module rf_rd_stage #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/bytemask_regfile.sv
module bytemask_regfile #(
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned LANE_W   = 8,
   localparam int unsigned LANES   = rf_pkg::lanes_of(DATA_W, LANE_W),
   localparam int unsigned ADDR_W  = rf_pkg::idx_bits(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] pa_addr,
   input  logic [DATA_W-1:0] pa_wdata,
   input  logic [LANES-1:0]  pa_lane_we,
   output logic [DATA_W-1:0] pa_rdata,
   input  logic [ADDR_W-1:0] pb_addr,
   output logic [DATA_W-1:0] pb_rdata
);
   generate
      if (DATA_W % LANE_W != 0) begin : g_bad_lane
         $error("DATA_W must be a whole number of lanes");
      end
      if (NUM_REGS < 2) begin : g_bad_depth
         $error("NUM_REGS must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] word_a;
   logic [DATA_W-1:0] word_b;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         rf_lane_bank #(.DEPTH(NUM_REGS), .LANE_W(LANE_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (pa_lane_we[g]),
            .waddr   (pa_addr),
            .wdata   (pa_wdata[g*LANE_W +: LANE_W]),
            .raddr_a (pa_addr),
            .raddr_b (pb_addr),
            .rlane_a (word_a[g*LANE_W +: LANE_W]),
            .rlane_b (word_b[g*LANE_W +: LANE_W])
         );
      end
   endgenerate

   rf_rd_stage #(.W(DATA_W)) u_rd_a (
      .clk (clk), .rst_n (rst_n), .d (word_a), .q (pa_rdata));
   rf_rd_stage #(.W(DATA_W)) u_rd_b (
      .clk (clk), .rst_n (rst_n), .d (word_b), .q (pb_rdata));

   // R5
   coll_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pa_lane_we != '0 && pa_addr == pb_addr) |=> pb_rdata == pa_rdata);

   // R7
   same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pa_addr == pb_addr) |=> pa_rdata == pb_rdata);

   // R1
   always @(negedge clk) begin
      if (rst_n == 1'b0) begin
         reset_zero_chk: assert (pa_rdata == '0 && pb_rdata == '0);
      end
   end
endmodule

// File: tb/sim_bytemask_regfile.sv
`timescale 1ns/1ps
module sim_bytemask_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  pa_addr = '0;
   logic [31:0] pa_wdata = '0;
   logic [3:0]  pa_lane_we = '0;
   logic [4:0]  pb_addr = '0;
   logic [31:0] pa_rdata, pb_rdata;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   logic [31:0] refm [32];
   logic [31:0] exp_a = '0;
   logic [31:0] exp_b = '0;

   always #4 clk = ~clk;

   bytemask_regfile u0 (
      .clk(clk), .rst_n(rst_n),
      .pa_addr(pa_addr), .pa_wdata(pa_wdata), .pa_lane_we(pa_lane_we),
      .pa_rdata(pa_rdata),
      .pb_addr(pb_addr), .pb_rdata(pb_rdata));

   // behavioural reference, updated on each rising edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) refm[i] = '0;
         exp_a = '0;
         exp_b = '0;
      end else begin
         exp_a = refm[pa_addr];
         exp_b = refm[pb_addr];
         for (int l = 0; l < 4; l++)
            if (pa_lane_we[l]) refm[pa_addr][l*8 +: 8] = pa_wdata[l*8 +: 8];
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // at the falling edge: compare both outputs, then drive the next inputs
   task automatic step(input logic [4:0] aa, input logic [31:0] wd,
                       input logic [3:0] be, input logic [4:0] ba);
      @(negedge clk);
      chk(cur_req, "port A", pa_rdata, exp_a);
      chk(cur_req, "port B", pb_rdata, exp_b);
      pa_addr = aa; pa_wdata = wd; pa_lane_we = be; pb_addr = ba;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs zero during reset
      chk("R1", "A in reset", pa_rdata, 32'h0);
      chk("R1", "B in reset", pb_rdata, 32'h0);
      rst_n = 1'b1;

      // R1: every register reads zero after reset
      cur_req = "R1";
      for (int r = 0; r < 32; r++) step(r[4:0], '0, 4'h0, 5'(31 - r));

      // R3: full writes, then partial masks
      cur_req = "R3";
      for (int r = 0; r < 32; r++) step(r[4:0], 32'hA5000000 ^ (r * 32'h01030507), 4'hF, 5'd0);
      step(5'd3, 32'h11223344, 4'b0101, 5'd3);
      step(5'd3, 32'hDEADBEEF, 4'b1000, 5'd3);
      step(5'd3, '0, 4'h0, 5'd3);
      step(5'd3, '0, 4'h0, 5'd3);
      // R3: walk every mask pattern on one register
      for (int m = 1; m < 16; m++) begin
         step(5'd7, 32'h0 + m * 32'h11111111, m[3:0], 5'd6);
         step(5'd7, '0, 4'h0, 5'd7);
      end

      // R2 and R7: independent addresses on both ports
      cur_req = "R2";
      for (int r = 0; r < 32; r++) step(r[4:0], '0, 4'h0, 5'(r ^ 5'h15));
      cur_req = "R7";
      for (int r = 0; r < 8; r++) step(r[4:0], '0, 4'h0, r[4:0]);

      // R4/R5: write reg 9 while both ports read it, then read it back
      cur_req = "R4";
      step(5'd9, 32'hCAFEF00D, 4'hF, 5'd9);
      cur_req = "R5";
      step(5'd9, 32'h0BADC0DE, 4'b0011, 5'd9);
      step(5'd9, '0, 4'h0, 5'd9);
      step(5'd9, '0, 4'h0, 5'd9);

      // R6: all-zero mask leaves storage unchanged
      cur_req = "R6";
      step(5'd12, 32'hFFFFFFFF, 4'h0, 5'd12);
      step(5'd12, 32'h12345678, 4'h0, 5'd12);
      step(5'd12, '0, 4'h0, 5'd12);
      step(5'd12, '0, 4'h0, 5'd12);

      // R8: inputs moved between edges do not reach the outputs
      cur_req = "R8";
      step(5'd1, '0, 4'h0, 5'd2);
      step(5'd1, '0, 4'h0, 5'd2);
      #1;
      pa_addr = 5'd20; pb_addr = 5'd21; pa_wdata = 32'h55AA55AA; pa_lane_we = 4'hF;
      #1;
      chk("R8", "A mid-cycle", pa_rdata, exp_a);
      chk("R8", "B mid-cycle", pb_rdata, exp_b);
      pa_addr = 5'd1; pb_addr = 5'd2; pa_wdata = '0; pa_lane_we = 4'h0;
      step(5'd20, '0, 4'h0, 5'd21);
      step(5'd20, '0, 4'h0, 5'd21);

      // mixed traffic
      cur_req = "R3";
      for (int i = 0; i < 400; i++)
         step(5'($urandom_range(31)), $urandom, 4'($urandom_range(15)), 5'($urandom_range(31)));
      step(5'd0, '0, 4'h0, 5'd0);

      // R1: reset in the middle of a run
      step(5'd5, 32'h77777777, 4'hF, 5'd5);
      step(5'd5, '0, 4'h0, 5'd5);
      @(negedge clk);
      #1;
      rst_n = 1'b0;
      #1;
      chk("R1", "A async reset", pa_rdata, 32'h0);
      chk("R1", "B async reset", pb_rdata, 32'h0);
      #4;
      rst_n = 1'b1;
      cur_req = "R1";
      step(5'd5, '0, 4'h0, 5'd5);
      step(5'd5, '0, 4'h0, 5'd5);
      step(5'd0, '0, 4'h0, 5'd0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule